// File: doc/BRIEF.md
# Execution Mode Switch Controller

This controller chooses between two execution styles for a core: a wide out-of-order style suited to a few threads, and a threaded in-order style in which many hardware threads issue in order. It counts the threads that are runnable, meaning present and not parked by a monitor/wait hint, and compares that count with a threshold. When the count calls for the other style, it runs the transition as a fixed series of steps. First it drains the pipeline. Then it has an external engine spill the architectural registers of every thread. Then it turns the clocks of the out-of-order-only units (rename, out-of-order wakeup/select, load queue) off or on. Last, it has the engine refill the register file.

The two directions are not mirror images. Going to in-order gates the units and refills every thread's register partition. Going to out-of-order ungates the units and writes one pulse into an active-thread table that records which threads are parked. It refills only the runnable threads and, on completion, signals the rename map tables to update. Spill and fill memory traffic are seen only as request/done handshakes. Fetch is held off for the whole transition. The mode output changes only when the transition completes.

Top module: `xms_mode_switch`

## Requirements
- R1: After reset, `mode_threaded` is 0 (out-of-order), `unit_clk_en` is all ones, and `busy`, `fetch_stall`, `spill_req`, `fill_req`, `park_we`, `map_upd` and `done` are 0.
- R2: The runnable count is the number of bits set in `thr_live & ~thr_wait`. The target is in-order (`mode_threaded`=1) when that count exceeds THRESH (2), and out-of-order otherwise. A switch starts only when the target differs from the current mode. A count of exactly 2 starts no switch out of out-of-order mode, and a count of 3 does.
- R3: After a switch starts, `spill_req` stays 0 until `pipe_empty` has been seen high.
- R4: `spill_req` stays high until `spill_done`. `unit_clk_en` does not change before `spill_done`. The clock enables are in their final state before `fill_req` rises. Bit 0 is rename, bit 1 is wakeup/select and bit 2 is the load queue.
- R5: In a switch to in-order, all three clock enables go to 0, `fill_mask` is all ones while `fill_req` is high, and `park_we` stays 0.
- R6: In a switch to out-of-order, all three clock enables go to 1. `park_we` pulses for one cycle between spill and fill, with `park_mask` equal to the inverse of the runnable mask captured when the switch started. `fill_mask` equals that captured runnable mask.
- R7: `busy` and `fetch_stall` are high from the cycle after the decision until fill completes. `mode_threaded` changes only in the cycle after `fill_done`, to the target mode.
- R8: `done` is a one-cycle pulse in the cycle after `fill_done`. `map_upd` pulses with it only when a switch to out-of-order completes.
- R9: Changes to the thread hints during a switch do not alter its target or fill mask. Once the controller is idle again, the count is re-evaluated and may start a new switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_live | input | NT | Thread context is present |
| thr_wait | input | NT | Thread parked by a monitor/wait hint |
| pipe_empty | input | 1 | Pipeline holds no instructions |
| spill_done | input | 1 | Register spill engine finished |
| fill_done | input | 1 | Register fill engine finished |
| spill_req | output | 1 | Request spill of all threads' registers |
| fill_req | output | 1 | Request register fill |
| fill_mask | output | NT | Threads to fill while `fill_req` is high |
| park_we | output | 1 | Write strobe for the active-thread table |
| park_mask | output | NT | Parked threads recorded with `park_we` |
| map_upd | output | 1 | Update speculative and committed map tables |
| unit_clk_en | output | 3 | Clock enables of out-of-order-only units |
| fetch_stall | output | 1 | Hold fetch during a switch |
| busy | output | 1 | Switch in progress |
| done | output | 1 | One-cycle switch completion pulse |
| mode_threaded | output | 1 | 1 = in-order threaded, 0 = out-of-order |

## Verification
The assertions assume that the spill and fill engines raise `spill_done` and `fill_done` only while the matching request is high. They also assume that `pipe_empty` means the same thing whenever the controller samples it. The bench models each engine as a task that pulses its done input for exactly one cycle and only after the request has been seen. It raises `pipe_empty` only after holding it low for a chosen drain time. The hint inputs are changed in the middle of a switch only in the scenario that exercises R9.

// File: rtl/xms_pkg.sv
package xms_pkg;

    typedef enum logic [2:0] {
        SW_IDLE  = 3'd0,
        SW_DRAIN = 3'd1,
        SW_SPILL = 3'd2,
        SW_GATE  = 3'd3,
        SW_FILL  = 3'd4
    } sw_state_t;

    typedef enum logic {
        XM_WIDE     = 1'b0,
        XM_THREADED = 1'b1
    } xmode_t;

    localparam int unsigned GATED_UNITS = 3;
    localparam int unsigned UNIT_RENAME = 0;
    localparam int unsigned UNIT_SCHED  = 1;
    localparam int unsigned UNIT_LOADQ  = 2;

    typedef struct packed {
        logic gate_on;
        logic gate_off;
    } gate_cmd_t;

endpackage

// File: rtl/xms_census.sv
module xms_census #(
    parameter int NT = 8,
    localparam int CW = $clog2(NT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] thr_live,
    input  logic [NT-1:0] thr_wait,
    output logic [NT-1:0] act_mask,
    output logic [CW-1:0] act_cnt
);
    logic [NT-1:0] run_now;
    logic [CW-1:0] cnt_now;

    always_comb begin
        run_now = thr_live & ~thr_wait;
        cnt_now = '0;
        for (int i = 0; i < NT; i++) begin
            cnt_now = cnt_now + CW'(run_now[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mask <= '0;
            act_cnt  <= '0;
        end else begin
            act_mask <= run_now;
            act_cnt  <= cnt_now;
        end
    end

    // R2
    cnt_match_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (act_cnt == CW'($countones($past(run_now)))));

endmodule

// File: rtl/xms_gate_bank.sv
module xms_gate_bank
    import xms_pkg::*;
#(
    parameter int NU = GATED_UNITS
) (
    input  logic          clk,
    input  logic          rst,
    input  gate_cmd_t     cmd,
    output logic [NU-1:0] clk_en
);
    for (genvar u = 0; u < NU; u++) begin : g_unit
        always_ff @(posedge clk) begin
            if (rst)               clk_en[u] <= 1'b1;
            else if (cmd.gate_on)  clk_en[u] <= 1'b1;
            else if (cmd.gate_off) clk_en[u] <= 1'b0;
        end
    end

    // R4
    gate_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd.gate_on && cmd.gate_off));

endmodule

// File: rtl/xms_sequencer.sv
module xms_sequencer
    import xms_pkg::*;
#(
    parameter int NT     = 8,
    parameter int THRESH = 2,
    localparam int CW = $clog2(NT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NT-1:0] act_mask,
    input  logic [CW-1:0] act_cnt,
    input  logic          pipe_empty,
    input  logic          spill_done,
    input  logic          fill_done,
    output logic          spill_req,
    output logic          fill_req,
    output logic [NT-1:0] fill_mask,
    output logic          park_we,
    output logic [NT-1:0] park_mask,
    output logic          map_upd,
    output gate_cmd_t     gate_cmd,
    output logic          busy,
    output logic          fetch_stall,
    output logic          done,
    output logic          mode_threaded
);
    sw_state_t     st_q, st_d;
    xmode_t        mode_q, dest_q;
    logic [NT-1:0] snap_q;
    logic          done_q, map_q;
    xmode_t        want;

    always_comb begin
        want = (act_cnt > CW'(THRESH)) ? XM_THREADED : XM_WIDE;
        st_d = st_q;
        case (st_q)
            SW_IDLE:  if (want != mode_q) st_d = SW_DRAIN;
            SW_DRAIN: if (pipe_empty)     st_d = SW_SPILL;
            SW_SPILL: if (spill_done)     st_d = SW_GATE;
            SW_GATE:                      st_d = SW_FILL;
            SW_FILL:  if (fill_done)      st_d = SW_IDLE;
            default:                      st_d = SW_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= SW_IDLE;
            mode_q <= XM_WIDE;
            dest_q <= XM_WIDE;
            snap_q <= '0;
            done_q <= 1'b0;
            map_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= 1'b0;
            map_q  <= 1'b0;
            if (st_q == SW_IDLE && want != mode_q) begin
                dest_q <= want;
                snap_q <= act_mask;
            end
            if (st_q == SW_FILL && fill_done) begin
                mode_q <= dest_q;
                done_q <= 1'b1;
                map_q  <= (dest_q == XM_WIDE);
            end
        end
    end

    always_comb begin
        busy             = (st_q != SW_IDLE);
        fetch_stall      = busy;
        spill_req        = (st_q == SW_SPILL);
        fill_req         = (st_q == SW_FILL);
        fill_mask        = '0;
        if (fill_req) fill_mask = (dest_q == XM_THREADED) ? '1 : snap_q;
        park_we          = (st_q == SW_GATE) && (dest_q == XM_WIDE);
        park_mask        = park_we ? ~snap_q : '0;
        gate_cmd.gate_off = spill_req && spill_done && (dest_q == XM_THREADED);
        gate_cmd.gate_on  = spill_req && spill_done && (dest_q == XM_WIDE);
        done             = done_q;
        map_upd          = map_q;
        mode_threaded    = (mode_q == XM_THREADED);
    end

    // R3
    spill_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spill_req) |-> $past(pipe_empty));

    // R4
    spill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (spill_req && !spill_done) |=> spill_req);

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(mode_threaded) |-> done);

    // R7
    fill_stall_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> fetch_stall);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    map_dir_chk: assert property (@(posedge clk) disable iff (rst)
        map_upd |-> (done && !mode_threaded));

endmodule

// File: rtl/xms_mode_switch.sv
module xms_mode_switch
    import xms_pkg::*;
#(
    parameter int NT     = 8,
    parameter int THRESH = 2,
    localparam int CW = $clog2(NT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NT-1:0]          thr_live,
    input  logic [NT-1:0]          thr_wait,
    input  logic                   pipe_empty,
    input  logic                   spill_done,
    input  logic                   fill_done,
    output logic                   spill_req,
    output logic                   fill_req,
    output logic [NT-1:0]          fill_mask,
    output logic                   park_we,
    output logic [NT-1:0]          park_mask,
    output logic                   map_upd,
    output logic [GATED_UNITS-1:0] unit_clk_en,
    output logic                   fetch_stall,
    output logic                   busy,
    output logic                   done,
    output logic                   mode_threaded
);
    logic [NT-1:0] act_mask;
    logic [CW-1:0] act_cnt;
    gate_cmd_t     gate_cmd;

    xms_census #(.NT(NT)) u_census (
        .clk      (clk),
        .rst      (rst),
        .thr_live (thr_live),
        .thr_wait (thr_wait),
        .act_mask (act_mask),
        .act_cnt  (act_cnt)
    );

    xms_sequencer #(.NT(NT), .THRESH(THRESH)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .act_mask      (act_mask),
        .act_cnt       (act_cnt),
        .pipe_empty    (pipe_empty),
        .spill_done    (spill_done),
        .fill_done     (fill_done),
        .spill_req     (spill_req),
        .fill_req      (fill_req),
        .fill_mask     (fill_mask),
        .park_we       (park_we),
        .park_mask     (park_mask),
        .map_upd       (map_upd),
        .gate_cmd      (gate_cmd),
        .busy          (busy),
        .fetch_stall   (fetch_stall),
        .done          (done),
        .mode_threaded (mode_threaded)
    );

    xms_gate_bank #(.NU(GATED_UNITS)) u_gates (
        .clk    (clk),
        .rst    (rst),
        .cmd    (gate_cmd),
        .clk_en (unit_clk_en)
    );

    // R4
    fill_gate_chk: assert property (@(posedge clk) disable iff (rst)
        fill_req |-> (unit_clk_en == (mode_threaded ? {GATED_UNITS{1'b1}}
                                                    : {GATED_UNITS{1'b0}})));

    // R4
    gate_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !spill_req) |=> (spill_req || $stable(unit_clk_en) || $past(spill_req)));

endmodule

// File: tb/xms_mode_switch_tb.sv
`timescale 1ns/1ps
module xms_mode_switch_tb;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NT-1:0] thr_live, thr_wait;
    logic          pipe_empty, spill_done, fill_done;
    logic          spill_req, fill_req, park_we, map_upd;
    logic [NT-1:0] fill_mask, park_mask;
    logic [2:0]    unit_clk_en;
    logic          fetch_stall, busy, done, mode_threaded;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    xms_mode_switch #(.NT(NT), .THRESH(2)) u_dut (
        .clk(clk), .rst(rst), .thr_live(thr_live), .thr_wait(thr_wait),
        .pipe_empty(pipe_empty), .spill_done(spill_done), .fill_done(fill_done),
        .spill_req(spill_req), .fill_req(fill_req), .fill_mask(fill_mask),
        .park_we(park_we), .park_mask(park_mask), .map_upd(map_upd),
        .unit_clk_en(unit_clk_en), .fetch_stall(fetch_stall), .busy(busy),
        .done(done), .mode_threaded(mode_threaded)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; thr_live = '0; thr_wait = '0;
        pipe_empty = 1'b0; spill_done = 1'b0; fill_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(mode_threaded == 1'b0, "R1 mode", 32'(mode_threaded), 0);
        chk(unit_clk_en == 3'b111, "R1 clk_en", 32'(unit_clk_en), 7);
        chk({busy, fetch_stall, spill_req, fill_req, park_we, map_upd, done} == '0,
            "R1 idle outputs", 32'({busy, fetch_stall, spill_req, fill_req, park_we, map_upd, done}), 0);
    endtask

    task automatic t_no_switch(input logic [NT-1:0] live, input logic [NT-1:0] wt,
                               input logic exp_mode, input string tag);
        bit quiet = 1'b1;
        thr_live = live; thr_wait = wt;
        repeat (12) begin
            @(negedge clk);
            if (busy) quiet = 1'b0;
        end
        // R2
        chk(quiet, tag, 32'(busy), 0);
        chk(mode_threaded == exp_mode, {tag, " mode"}, 32'(mode_threaded), 32'(exp_mode));
    endtask

    task automatic t_switch(input logic to_thr, input logic [NT-1:0] exp_fill,
                            input logic [NT-1:0] exp_park, input bit meddle,
                            input logic [NT-1:0] m_live, input logic [NT-1:0] m_wait,
                            input int drain_cyc);
        bit started = 1'b0;
        bit held = 1'b1;
        bit hold_ok = 1'b1;
        logic [2:0] exp_en = to_thr ? 3'b000 : 3'b111;
        logic [2:0] old_en = unit_clk_en;
        logic old_mode = mode_threaded;
        for (int k = 0; k < 8 && !started; k++) begin
            @(negedge clk);
            if (busy) started = 1'b1;
        end
        // R2
        chk(started, "R2 switch starts", 32'(busy), 1);
        // R7
        chk(fetch_stall, "R7 fetch stalled", 32'(fetch_stall), 1);
        if (meddle) begin thr_live = m_live; thr_wait = m_wait; end
        for (int k = 0; k < drain_cyc; k++) begin
            @(negedge clk);
            if (spill_req) held = 1'b0;
        end
        // R3
        chk(held, "R3 no spill before drain", 32'(spill_req), 0);
        pipe_empty = 1'b1;
        started = 1'b0;
        for (int k = 0; k < 4 && !started; k++) begin
            @(negedge clk);
            if (spill_req) started = 1'b1;
        end
        pipe_empty = 1'b0;
        // R3
        chk(started, "R3 spill after drain", 32'(spill_req), 1);
        repeat (250) begin
            @(negedge clk);
            if (!spill_req || unit_clk_en != old_en || fill_req) hold_ok = 1'b0;
        end
        // R4
        chk(hold_ok, "R4 spill held, gates unchanged", 32'(unit_clk_en), 32'(old_en));
        spill_done = 1'b1;
        @(negedge clk);
        spill_done = 1'b0;
        // R4 R5 R6
        chk(unit_clk_en == exp_en, "R4 gates switched before fill", 32'(unit_clk_en), 32'(exp_en));
        chk(park_we == !to_thr, "R6 park strobe", 32'(park_we), 32'(!to_thr));
        if (!to_thr)
            chk(park_mask == exp_park, "R6 park mask", 32'(park_mask), 32'(exp_park));
        chk(!spill_req && !fill_req, "R4 gap cycle", 32'({spill_req, fill_req}), 0);
        @(negedge clk);
        // R5 R6 R9
        chk(fill_req, "R4 fill requested", 32'(fill_req), 1);
        chk(fill_mask == exp_fill, to_thr ? "R5 fill mask" : "R6 fill mask", 32'(fill_mask), 32'(exp_fill));
        chk(park_we == 1'b0, "R6 park single pulse", 32'(park_we), 0);
        // R7
        chk(mode_threaded == old_mode && busy, "R7 mode held during fill", 32'(mode_threaded), 32'(old_mode));
        repeat (5) @(negedge clk);
        fill_done = 1'b1;
        @(negedge clk);
        fill_done = 1'b0;
        // R7 R8
        chk(mode_threaded == to_thr, "R7 mode at completion", 32'(mode_threaded), 32'(to_thr));
        chk(done, "R8 done pulse", 32'(done), 1);
        chk(map_upd == !to_thr, "R8 map update", 32'(map_upd), 32'(!to_thr));
        chk(!busy && !fetch_stall, "R7 busy released", 32'({busy, fetch_stall}), 0);
        @(negedge clk);
        chk(!done && !map_upd, "R8 one-cycle pulses", 32'({done, map_upd}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_no_switch(8'h03, 8'h00, 1'b0, "R2 two runnable stays wide");
        t_no_switch(8'hFF, 8'hFC, 1'b0, "R2 two of eight via waits");
        thr_live = 8'h07; thr_wait = 8'h00;
        t_switch(1'b1, 8'hFF, 8'h00, 1'b0, '0, '0, 20);
        t_no_switch(8'hFF, 8'hE0, 1'b1, "R2 five runnable stays threaded");
        thr_live = 8'hFF; thr_wait = 8'hFC;
        t_switch(1'b0, 8'h03, 8'hFC, 1'b0, '0, '0, 7);
        // R9: hints drop to one runnable mid-switch; target stays threaded
        thr_live = 8'h0F; thr_wait = 8'h00;
        t_switch(1'b1, 8'hFF, 8'h00, 1'b1, 8'h0F, 8'h0E, 10);
        // R9: re-evaluated when idle, returns to wide with thread 0 only
        t_switch(1'b0, 8'h01, 8'hFE, 1'b0, '0, '0, 3);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule